// File: doc/BRIEF.md
# CAN Controller Mode-Gated Register Bank

This block is the processor-facing register file of a CAN controller. It holds the controller's mode, interrupt-enable, bit-timing and warning-limit settings, a read-only status word, the most recently received frame and the frame to be sent. Software reaches the registers through a plain address / read / write bus. The protocol engine receives a set of mode controls from the block. These are a disable level, a one-cycle abort request, an acknowledge enable and a transmit enable.

The mode register has two bits. Bit 0 is the reset-mode bit and bit 1 is the listen-only bit. The reset-mode bit decides which registers software may change. Timing, warning limit and the receive registers can be written only while reset mode is active. The status register can never be written. Interrupt enable and the transmit registers can be written at any time. A write to a register that is locked in the current mode is dropped without notice. A bus-off event from the protocol engine forces reset mode on and leaves listen-only as it was. A hardware reset puts the block in reset mode with listen-only cleared.

Top module: `canreg_bank`

## Requirements
- R1: After hardware reset, the mode register reads 0x1 (reset mode 1, listen-only 0) and the warning limit reads 0x60. Every other register reads 0. The outputs are canDisable=1, ackEn=1, txEn=0 and abortReq=0.
- R2: Mode register bit 0 is reset mode and bit 1 is listen-only. Bits 31..2 always read 0, whatever was written to them.
- R3: A busOff pulse sets reset mode at the next clock edge and leaves listen-only unchanged. If busOff coincides with a software write that clears reset mode, busOff wins.
- R4: The timing register (address 2, 24 bits) and the warning-limit register (address 3, 8 bits) accept writes only while reset mode is 1. In operating mode a write to either is dropped.
- R5: The status register (address 4, 8 bits) reads the value of statusIn sampled at the previous clock edge. Writes to it are ignored in both modes.
- R6: The receive registers are info (address 5), identifier (address 6, 29 bits), data low (address 7) and data high (address 8).
  - Software can write them only while reset mode is 1.
  - rxValid loads them from rxInfoIn, rxIdIn and rxDataIn (low word in bits 31..0) only while reset mode is 0. In reset mode rxValid is ignored.
- R7: Interrupt enable (address 1, 11 bits) and the transmit registers accept writes in both modes. The transmit registers are info (address 9), identifier (address 10, 29 bits), data low (address 11) and data high (address 12).
- R8: abortReq is high for exactly one cycle after each 0-to-1 change of reset mode, whether software or busOff caused it. Hardware reset does not raise it.
- R9: canDisable equals reset mode, ackEn equals NOT listen-only, and txEn equals NOT (reset mode OR listen-only).
- R10: Read data is registered:
  - cpuRdata takes the addressed register at the clock edge where cpuRd is high, and holds its value otherwise.
  - Unmapped addresses read 0.
  - Fields narrower than 32 bits are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| cpuAddr | input | 4 | Register address |
| cpuWr | input | 1 | Write strobe |
| cpuRd | input | 1 | Read strobe |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Registered read data |
| busOff | input | 1 | Bus-off event from the protocol engine |
| rxValid | input | 1 | A frame was received; load the receive registers |
| rxInfoIn | input | 32 | Received frame info |
| rxIdIn | input | 29 | Received identifier |
| rxDataIn | input | 64 | Received data, low word in bits 31..0 |
| statusIn | input | 8 | Live status from the protocol engine |
| canDisable | output | 1 | Protocol engine disabled (reset mode) |
| abortReq | output | 1 | One-cycle abort of any frame in progress |
| ackEn | output | 1 | Engine may acknowledge received frames |
| txEn | output | 1 | Engine may transmit |

## Verification
The assertions assume three things about the inputs:
- busOff and rxValid are single-cycle events.
- statusIn and the receive inputs are driven to known values from time zero.
- No register write lands on the same edge as a reset release.

The bench drives every input at the falling clock edge, starting from defined zeros. It holds busOff and rxValid for exactly one cycle. It starts bus transactions only after reset has been released for several cycles. These choices keep the properties on locked-register stability, bus-off entry and abort pulse width within what the design promises.

// File: rtl/canreg_pkg.sv
package canreg_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MODE    = 4'd0;
  localparam logic [ADDR_W-1:0] A_IRQEN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_TIMING  = 4'd2;
  localparam logic [ADDR_W-1:0] A_WARN    = 4'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXINFO  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXID    = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXDATA0 = 4'd7;
  localparam logic [ADDR_W-1:0] A_RXDATA1 = 4'd8;
  localparam logic [ADDR_W-1:0] A_TXINFO  = 4'd9;
  localparam logic [ADDR_W-1:0] A_TXID    = 4'd10;
  localparam logic [ADDR_W-1:0] A_TXDATA0 = 4'd11;
  localparam logic [ADDR_W-1:0] A_TXDATA1 = 4'd12;

  localparam int unsigned DATA_WORDS = 2;

  // Mode-qualified write strobes from control to datapath
  typedef struct packed {
    logic                  mode;
    logic                  irqEn;
    logic                  timing;
    logic                  warnLim;
    logic                  rxInfo;
    logic                  rxId;
    logic [DATA_WORDS-1:0] rxData;
    logic                  txInfo;
    logic                  txId;
    logic [DATA_WORDS-1:0] txData;
  } wrStrobe_t;
endpackage

// File: rtl/canreg_ctrl.sv
module canreg_ctrl
  import canreg_pkg::*;
(
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              rmNow,
  output wrStrobe_t         wrStb
);
  // Decode the address and gate each strobe with the access rule of the current mode
  always_comb begin
    wrStb = '0;
    if (cpuWr) begin
      unique case (cpuAddr)
        A_MODE:    wrStb.mode      = 1'b1;
        A_IRQEN:   wrStb.irqEn     = 1'b1;          // R7: open in both modes
        A_TIMING:  wrStb.timing    = rmNow;         // R4
        A_WARN:    wrStb.warnLim   = rmNow;         // R4
        A_RXINFO:  wrStb.rxInfo    = rmNow;         // R6
        A_RXID:    wrStb.rxId      = rmNow;         // R6
        A_RXDATA0: wrStb.rxData[0] = rmNow;
        A_RXDATA1: wrStb.rxData[1] = rmNow;
        A_TXINFO:  wrStb.txInfo    = 1'b1;          // R7
        A_TXID:    wrStb.txId      = 1'b1;
        A_TXDATA0: wrStb.txData[0] = 1'b1;
        A_TXDATA1: wrStb.txData[1] = 1'b1;
        default:   wrStb = '0;                      // R5: status and unmapped take no write
      endcase
    end
  end
endmodule

// File: rtl/canreg_dp.sv
module canreg_dp
  import canreg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IRQEN_W = 11,
  parameter int unsigned BT_W    = 24,
  parameter int unsigned EWL_W   = 8,
  parameter int unsigned ST_W    = 8,
  parameter int unsigned ID_W    = 29,
  parameter logic [EWL_W-1:0] EWL_RST = 8'h60
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wrStrobe_t                    wrStb,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic                         cpuRd,
  input  logic [DATA_W-1:0]            cpuWdata,
  output logic [DATA_W-1:0]            cpuRdata,
  input  logic                         busOff,
  input  logic                         rxValid,
  input  logic [DATA_W-1:0]            rxInfoIn,
  input  logic [ID_W-1:0]              rxIdIn,
  input  logic [DATA_WORDS*DATA_W-1:0] rxDataIn,
  input  logic [ST_W-1:0]              statusIn,
  output logic                         rmNow,
  output logic                         abortReq,
  output logic                         ackEn,
  output logic                         txEn
);
  logic rmQ, lomQ, rmPrevQ;
  logic [IRQEN_W-1:0] irqEnQ;
  logic [BT_W-1:0]    timingQ;
  logic [EWL_W-1:0]   warnQ;
  logic [ST_W-1:0]    statusQ;
  logic [DATA_W-1:0]  rxInfoQ, txInfoQ;
  logic [ID_W-1:0]    rxIdQ, txIdQ;
  logic [DATA_W-1:0]  rxDataQ [DATA_WORDS];
  logic [DATA_W-1:0]  txDataQ [DATA_WORDS];
  logic [DATA_W-1:0]  rdMux, rdQ;
  logic               rxLoad;

  assign rxLoad = rxValid & ~rmQ;   // R6: engine loads only in operating mode

  // Mode register: bus-off has priority over a software write (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rmQ     <= 1'b1;
      lomQ    <= 1'b0;
      rmPrevQ <= 1'b1;
    end else begin
      rmPrevQ <= rmQ;
      if (busOff)          rmQ <= 1'b1;
      else if (wrStb.mode) rmQ <= cpuWdata[0];
      if (wrStb.mode)      lomQ <= cpuWdata[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ  <= '0;
      timingQ <= '0;
      warnQ   <= EWL_RST;
      statusQ <= '0;
      rxInfoQ <= '0;
      rxIdQ   <= '0;
      txInfoQ <= '0;
      txIdQ   <= '0;
    end else begin
      statusQ <= statusIn;
      if (wrStb.irqEn)   irqEnQ  <= cpuWdata[IRQEN_W-1:0];
      if (wrStb.timing)  timingQ <= cpuWdata[BT_W-1:0];
      if (wrStb.warnLim) warnQ   <= cpuWdata[EWL_W-1:0];
      if (rxLoad)            rxInfoQ <= rxInfoIn;
      else if (wrStb.rxInfo) rxInfoQ <= cpuWdata;
      if (rxLoad)            rxIdQ   <= rxIdIn;
      else if (wrStb.rxId)   rxIdQ   <= cpuWdata[ID_W-1:0];
      if (wrStb.txInfo)  txInfoQ <= cpuWdata;
      if (wrStb.txId)    txIdQ   <= cpuWdata[ID_W-1:0];
    end
  end

  // Data words: one register pair per word
  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxDataQ[w] <= '0;
        txDataQ[w] <= '0;
      end else begin
        if (rxLoad)               rxDataQ[w] <= rxDataIn[w*DATA_W +: DATA_W];
        else if (wrStb.rxData[w]) rxDataQ[w] <= cpuWdata;
        if (wrStb.txData[w])      txDataQ[w] <= cpuWdata;
      end
    end
  end

  // Read mux with zero extension (R2, R10)
  always_comb begin
    unique case (cpuAddr)
      A_MODE:    rdMux = DATA_W'({lomQ, rmQ});
      A_IRQEN:   rdMux = DATA_W'(irqEnQ);
      A_TIMING:  rdMux = DATA_W'(timingQ);
      A_WARN:    rdMux = DATA_W'(warnQ);
      A_STATUS:  rdMux = DATA_W'(statusQ);
      A_RXINFO:  rdMux = rxInfoQ;
      A_RXID:    rdMux = DATA_W'(rxIdQ);
      A_RXDATA0: rdMux = rxDataQ[0];
      A_RXDATA1: rdMux = rxDataQ[1];
      A_TXINFO:  rdMux = txInfoQ;
      A_TXID:    rdMux = DATA_W'(txIdQ);
      A_TXDATA0: rdMux = txDataQ[0];
      A_TXDATA1: rdMux = txDataQ[1];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdQ <= '0;
    else if (cpuRd) rdQ <= rdMux;
  end

  assign cpuRdata = rdQ;
  assign rmNow    = rmQ;
  assign abortReq = rmQ & ~rmPrevQ;     // R8
  assign ackEn    = ~lomQ;              // R9
  assign txEn     = ~(rmQ | lomQ);

  // Assertions
  a_r3_busoff_enters_reset: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> rmQ);
  a_r3_busoff_keeps_listen: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !wrStb.mode) |=> (lomQ == $past(lomQ)));
  a_r4_timing_locked: assert property (@(posedge clk) disable iff (!rstN)
    !rmQ |=> $stable(timingQ));
  a_r4_warn_locked: assert property (@(posedge clk) disable iff (!rstN)
    !rmQ |=> $stable(warnQ));
  a_r6_rxid_quiet_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    (rmQ && !wrStb.rxId) |=> $stable(rxIdQ));
  a_r8_abort_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq);
  a_r8_abort_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!rmQ && busOff) |=> abortReq);
endmodule

// File: rtl/canreg_bank.sv
module canreg_bank
  import canreg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IRQEN_W = 11,
  parameter int unsigned BT_W    = 24,
  parameter int unsigned EWL_W   = 8,
  parameter int unsigned ST_W    = 8,
  parameter int unsigned ID_W    = 29,
  parameter logic [EWL_W-1:0] EWL_RST = 8'h60
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic                         cpuWr,
  input  logic                         cpuRd,
  input  logic [DATA_W-1:0]            cpuWdata,
  output logic [DATA_W-1:0]            cpuRdata,
  input  logic                         busOff,
  input  logic                         rxValid,
  input  logic [DATA_W-1:0]            rxInfoIn,
  input  logic [ID_W-1:0]              rxIdIn,
  input  logic [DATA_WORDS*DATA_W-1:0] rxDataIn,
  input  logic [ST_W-1:0]              statusIn,
  output logic                         canDisable,
  output logic                         abortReq,
  output logic                         ackEn,
  output logic                         txEn
);
  wrStrobe_t wrStb;
  logic      rmNow;

  canreg_ctrl u_ctrl (
    .cpuWr   (cpuWr),
    .cpuAddr (cpuAddr),
    .rmNow   (rmNow),
    .wrStb   (wrStb)
  );

  canreg_dp #(
    .DATA_W (DATA_W), .IRQEN_W (IRQEN_W), .BT_W (BT_W), .EWL_W (EWL_W),
    .ST_W (ST_W), .ID_W (ID_W), .EWL_RST (EWL_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .cpuAddr  (cpuAddr),
    .cpuRd    (cpuRd),
    .cpuWdata (cpuWdata),
    .cpuRdata (cpuRdata),
    .busOff   (busOff),
    .rxValid  (rxValid),
    .rxInfoIn (rxInfoIn),
    .rxIdIn   (rxIdIn),
    .rxDataIn (rxDataIn),
    .statusIn (statusIn),
    .rmNow    (rmNow),
    .abortReq (abortReq),
    .ackEn    (ackEn),
    .txEn     (txEn)
  );

  assign canDisable = rmNow;   // R9

  a_r9_tx_blocked: assert property (@(posedge clk) disable iff (!rstN)
    txEn |-> (!canDisable && ackEn));
endmodule

// File: tb/canreg_bank_test.sv
module canreg_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cpuAddr = '0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        busOff = 1'b0, rxValid = 1'b0;
  logic [31:0] rxInfoIn = '0;
  logic [28:0] rxIdIn = '0;
  logic [63:0] rxDataIn = '0;
  logic [7:0]  statusIn = '0;
  logic        canDisable, abortReq, ackEn, txEn;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  canreg_bank uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .busOff(busOff), .rxValid(rxValid),
    .rxInfoIn(rxInfoIn), .rxIdIn(rxIdIn), .rxDataIn(rxDataIn), .statusIn(statusIn),
    .canDisable(canDisable), .abortReq(abortReq), .ackEn(ackEn), .txEn(txEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWdata = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1;
    @(negedge clk);
    cpuRd = 1'b0;
    d = cpuRdata;
  endtask

  // Vector: [40] read, [39:36] addr, [35:4] data or expected, [3:0] requirement number
  localparam int NV = 26;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 4'd2,  32'hFFFFFFFF, 4'd4},  // R4 timing, reset mode
    {1'b1, 4'd2,  32'h00FFFFFF, 4'd4},
    {1'b0, 4'd3,  32'h000000AB, 4'd4},  // R4 warning limit
    {1'b1, 4'd3,  32'h000000AB, 4'd4},
    {1'b0, 4'd5,  32'h12345678, 4'd6},  // R6 rx info writable in reset mode
    {1'b1, 4'd5,  32'h12345678, 4'd6},
    {1'b0, 4'd6,  32'hFFFFFFFF, 4'd6},  // R6 rx id, 29 bits
    {1'b1, 4'd6,  32'h1FFFFFFF, 4'd6},
    {1'b0, 4'd1,  32'h0000FFFF, 4'd7},  // R7 irq enable, 11 bits
    {1'b1, 4'd1,  32'h000007FF, 4'd7},
    {1'b0, 4'd4,  32'hFFFFFFFF, 4'd5},  // R5 status write ignored
    {1'b1, 4'd4,  32'h00000000, 4'd5},
    {1'b0, 4'd0,  32'hFFFFFFFC, 4'd2},  // R2 leave reset mode, reserved bits set
    {1'b1, 4'd0,  32'h00000000, 4'd2},
    {1'b0, 4'd2,  32'h00000000, 4'd4},  // R4 dropped in operating mode
    {1'b1, 4'd2,  32'h00FFFFFF, 4'd4},
    {1'b0, 4'd3,  32'h00000000, 4'd4},
    {1'b1, 4'd3,  32'h000000AB, 4'd4},
    {1'b0, 4'd5,  32'h00000000, 4'd6},  // R6 dropped in operating mode
    {1'b1, 4'd5,  32'h12345678, 4'd6},
    {1'b0, 4'd9,  32'hCAFEF00D, 4'd7},  // R7 tx info in operating mode
    {1'b1, 4'd9,  32'hCAFEF00D, 4'd7},
    {1'b0, 4'd1,  32'h00000005, 4'd7},
    {1'b1, 4'd1,  32'h00000005, 4'd7},
    {1'b0, 4'd12, 32'h89ABCDEF, 4'd7},  // R7 tx data high
    {1'b1, 4'd15, 32'h00000000, 4'd10}  // R10 unmapped reads zero
  };

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 canDisable", {31'd0, canDisable}, 32'd1);
    check("R1 ackEn", {31'd0, ackEn}, 32'd1);
    check("R1 txEn", {31'd0, txEn}, 32'd0);
    check("R1 abortReq", {31'd0, abortReq}, 32'd0);
    cpuRead(4'd0, rd);  check("R1 mode", rd, 32'h1);
    cpuRead(4'd3, rd);  check("R1 warn", rd, 32'h60);
    cpuRead(4'd10, rd); check("R1 txId", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        cpuRead(VEC[i][39:36], rd);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end else begin
        cpuWrite(VEC[i][39:36], VEC[i][35:4]);
      end
    end
    cpuRead(4'd12, rd); check("R7 txData1", rd, 32'h89ABCDEF);

    // R9 outputs in operating mode
    check("R9 canDisable op", {31'd0, canDisable}, 32'd0);
    check("R9 txEn op", {31'd0, txEn}, 32'd1);

    // R6 engine load in operating mode
    @(negedge clk);
    rxValid = 1'b1; rxInfoIn = 32'hA5A5A5A5; rxIdIn = 29'h0ABCDEF1;
    rxDataIn = {32'h11112222, 32'h33334444};
    @(negedge clk);
    rxValid = 1'b0;
    cpuRead(4'd5, rd); check("R6 rx info load", rd, 32'hA5A5A5A5);
    cpuRead(4'd6, rd); check("R6 rx id load", rd, 32'h0ABCDEF1);
    cpuRead(4'd7, rd); check("R6 rx data lo", rd, 32'h33334444);
    cpuRead(4'd8, rd); check("R6 rx data hi", rd, 32'h11112222);

    // R5 status follows input
    @(negedge clk); statusIn = 8'h5A;
    cpuRead(4'd4, rd); check("R5 status", rd, 32'h5A);

    // R9 listen-only
    cpuWrite(4'd0, 32'h2);
    check("R9 ackEn lom", {31'd0, ackEn}, 32'd0);
    check("R9 txEn lom", {31'd0, txEn}, 32'd0);
    check("R9 canDisable lom", {31'd0, canDisable}, 32'd0);

    // R3 / R8 bus-off entry
    @(negedge clk); busOff = 1'b1;
    @(negedge clk); busOff = 1'b0;
    check("R3 busOff rm", {31'd0, canDisable}, 32'd1);
    check("R8 abort busOff", {31'd0, abortReq}, 32'd1);
    @(negedge clk);
    check("R8 abort width", {31'd0, abortReq}, 32'd0);
    cpuRead(4'd0, rd); check("R3 lom kept", rd, 32'h3);

    // R6 engine load ignored in reset mode
    @(negedge clk); rxValid = 1'b1; rxIdIn = 29'h5;
    @(negedge clk); rxValid = 1'b0;
    cpuRead(4'd6, rd); check("R6 rx ignored in reset", rd, 32'h0ABCDEF1);

    // R8 software entry
    cpuWrite(4'd0, 32'h0);
    check("R8 no abort on exit", {31'd0, abortReq}, 32'd0);
    cpuWrite(4'd0, 32'h1);
    check("R8 abort sw", {31'd0, abortReq}, 32'd1);
    @(negedge clk);
    check("R8 abort sw width", {31'd0, abortReq}, 32'd0);

    // R3 bus-off beats a simultaneous clear
    cpuWrite(4'd0, 32'h0);
    @(negedge clk);
    busOff = 1'b1; cpuAddr = 4'd0; cpuWdata = 32'h0; cpuWr = 1'b1;
    @(negedge clk);
    busOff = 1'b0; cpuWr = 1'b0;
    check("R3 busOff priority", {31'd0, canDisable}, 32'd1);

    // R10 read data holds without cpuRd
    cpuRead(4'd3, rd); check("R10 read", rd, 32'hAB);
    @(negedge clk); cpuAddr = 4'd1;
    @(negedge clk);
    check("R10 hold", cpuRdata, 32'hAB);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule